// File: doc/BRIEF.md
# Multi-Bank Chip-Select Wait-State Controller

This block sits between a processor bus and a set of external memories and peripherals. For each bus access it checks the address against a group of programmable banks. It then asserts the chip select of the winning bank, drives an output enable for reads and four byte-lane enables, and returns a transfer acknowledge after that bank's own wait-state count. An access that matches no bank gets a one-cycle error strobe in place of an acknowledge.

Each bank holds a base address and a control word. The control word sets the bank's enable, a power-of-two block size, its port width and a wait count from 0 to 15. It can also require the bus address-type code to equal a per-bank value. Bank 0 acts as the boot select: it is enabled out of reset, decodes the full address space and uses the slowest timing until software rewrites it. Bursts are fixed-length, and each beat is acknowledged on its own after the bank's wait count.

Top module: `csel_wait_ctrl`

## Requirements
- R1: After reset no chip select, acknowledge or error is active. Bank 0 is enabled with the whole address space, a 32-bit port and 15 wait states, so any first access selects bank 0. All other banks start disabled.
- R2: A write with `cfg_sel`=0 loads the bank's base address. A write with `cfg_sel`=1 loads its control word: bits 3:0 wait count, bits 7:4 size code, bits 9:8 port width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), bits 12:10 address-type value, bit 13 address-type check enable, bit 14 bank enable. Clearing bit 14 stops the bank from matching.
- R3: Size code c from 0 to 13 gives a block of 2^(15+c) bytes, from 32 KB to 256 MB. Only the address bits at and above bit 15+c are compared with the base. Codes 14 and 15 match every address.
- R4: When its address-type check is enabled, a bank matches only if `acc_type` equals its stored 3-bit value.
- R5: When several enabled banks match, the lowest-numbered one is selected.
- R6: An access that matches no bank asserts `terr` for exactly the one cycle after the capture edge. It asserts no chip select and no acknowledge.
- R7: The request is captured on a clock edge while the block is idle. The chip select is asserted from that edge, and `ta` is high in the (w+1)-th cycle after it, where w is the bank's wait count.
- R8: With `acc_burst` set, the access has 4 beats. Each later `ta` pulse comes w+2 cycles after the previous one, and the chip select stays asserted until the cycle after the last pulse.
- R9: Byte lane i covers address offset i. A 32-bit port enables lane addr[1:0] for a byte, lanes 3:2 or 1:0 (chosen by addr[1]) for a half-word, and all four lanes for a word. A 16-bit port enables lane addr[0] for a byte and lanes 1:0 otherwise. An 8-bit port enables lane 0. The `acc_size` field uses 0 for a byte, 1 for a half-word and 2 for a word. `oe` is high only during reads.
- R10: At most one chip select is active. A request raised while an access is in progress is ignored and does not start a second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 3 | Bank to configure |
| cfg_sel | input | 1 | 0 = base address, 1 = control word |
| cfg_wdata | input | 32 | Configuration data |
| acc_req | input | 1 | Access request, taken while idle |
| acc_addr | input | 32 | Access address |
| acc_type | input | 3 | Address-type code |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Transfer size code |
| acc_burst | input | 1 | 1 = four-beat burst |
| cs | output | 8 | Per-bank chip selects, active high |
| oe | output | 1 | Output enable for reads |
| be | output | 4 | Byte-lane enables |
| ta | output | 1 | Transfer acknowledge, one pulse per beat |
| terr | output | 1 | No-match error strobe |

## Verification
The embedded assertions check on every cycle that at most one chip select is active. They also check that an acknowledge or an output enable only appears under a chip select, that the error strobe never appears with a select or an acknowledge, that acknowledge pulses never run back to back, and that the select holds steady between pulses. The scenarios cover what the assertions cannot: exact wait-cycle counts per bank and per burst beat, which bank wins among overlapping ones, the size and type qualifiers, the lane patterns per port width, and the boot defaults. They also cover the fact that a request made while busy is dropped.

// File: rtl/csel_pkg.sv
package csel_pkg;
   // control word field positions
   localparam int F_WAIT_LO = 0;
   localparam int F_SIZE_LO = 4;
   localparam int F_PW_LO   = 8;
   localparam int F_AT_LO   = 10;
   localparam int F_AT_EN   = 13;
   localparam int F_VALID   = 14;
   localparam int CTL_W     = 15;
   localparam int AT_W      = 3;
   localparam int WAIT_W    = 4;
   localparam int SIZE_W    = 4;

   typedef enum logic [1:0] {PW_8 = 2'd0, PW_16 = 2'd1, PW_32 = 2'd2} port_w_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACC = 2'd1, ST_ERR = 2'd2} seq_st_e;

   function automatic logic [3:0] lane_mask(input logic [1:0] pw, input logic [1:0] sz,
                                            input logic [1:0] a);
      logic [3:0] m;
      if (pw == PW_8)       m = 4'b0001;
      else if (pw == PW_16) m = (sz == 2'd0) ? (a[0] ? 4'b0010 : 4'b0001) : 4'b0011;
      else if (sz == 2'd0)  m = 4'b0001 << a;
      else if (sz == 2'd1)  m = a[1] ? 4'b1100 : 4'b0011;
      else                  m = 4'b1111;
      return m;
   endfunction
endpackage

// File: rtl/csel_bank_regs.sv
module csel_bank_regs
   import csel_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 32,
   localparam int IDX_W    = $clog2(NUM_BANKS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [IDX_W-1:0]                    bank,
   input  logic                                sel,
   input  logic [ADDR_W-1:0]                   wdata,
   output logic [NUM_BANKS-1:0][ADDR_W-1:0]    base,
   output logic [NUM_BANKS-1:0][CTL_W-1:0]     ctl
);
   // boot bank: enabled, whole space, 32-bit port, slowest timing
   localparam logic [CTL_W-1:0] BOOT_CTL = CTL_W'((1 << F_VALID) | (2 << F_PW_LO) |
                                                  (15 << F_SIZE_LO) | (15 << F_WAIT_LO));

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      localparam logic [CTL_W-1:0] RST_CTL = (i == 0) ? BOOT_CTL : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base[i] <= '0;
            ctl[i]  <= RST_CTL;
         end else if (we && (int'(bank) == i)) begin
            if (sel) ctl[i]  <= wdata[CTL_W-1:0];
            else     base[i] <= wdata;
         end
      end
   end
endmodule

// File: rtl/csel_bank_match.sv
module csel_bank_match
   import csel_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 32,
   parameter int MIN_LOG2  = 15,
   parameter int MAX_CODE  = 13,
   localparam int IDX_W    = $clog2(NUM_BANKS)
) (
   input  logic [NUM_BANKS-1:0][ADDR_W-1:0] base,
   input  logic [NUM_BANKS-1:0][CTL_W-1:0]  ctl,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [AT_W-1:0]                  atype,
   output logic                             hit_any,
   output logic [IDX_W-1:0]                 win_idx
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
   logic [NUM_BANKS-1:0] hit;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cmp
      logic [SIZE_W-1:0] code;
      logic [ADDR_W-1:0] mask;
      logic              type_ok;
      assign code = ctl[i][F_SIZE_LO +: SIZE_W];
      always_comb begin
         if (int'(code) > MAX_CODE) mask = '0;
         else mask = ~((ONE << (MIN_LOG2 + int'(code))) - ONE);
      end
      assign type_ok = !ctl[i][F_AT_EN] || (atype == ctl[i][F_AT_LO +: AT_W]);
      assign hit[i]  = ctl[i][F_VALID] && (((addr ^ base[i]) & mask) == '0) && type_ok;
   end

   // lowest index wins
   always_comb begin
      win_idx = '0;
      for (int j = NUM_BANKS - 1; j >= 0; j--)
         if (hit[j]) win_idx = IDX_W'(j);
   end
   assign hit_any = |hit;
endmodule

// File: rtl/csel_wait_seq.sv
module csel_wait_seq
   import csel_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int BEATS     = 4,
   parameter bit BURST_EN  = 1'b1,
   localparam int IDX_W    = $clog2(NUM_BANKS),
   localparam int BEAT_W   = $clog2(BEATS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 hit_any,
   input  logic [IDX_W-1:0]     win_idx,
   input  logic [WAIT_W-1:0]    win_wait,
   input  logic [3:0]           win_lanes,
   input  logic                 write,
   input  logic                 burst,
   output logic [NUM_BANKS-1:0] cs,
   output logic                 oe,
   output logic [3:0]           be,
   output logic                 ta,
   output logic                 terr
);
   seq_st_e           st_q;
   logic [WAIT_W-1:0] cnt_q, wait_q;
   logic [BEAT_W-1:0] left_q, beats_m1;

   if (BURST_EN) begin : g_burst
      assign beats_m1 = burst ? BEAT_W'(BEATS - 1) : '0;
   end else begin : g_single
      assign beats_m1 = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; cnt_q <= '0; wait_q <= '0; left_q <= '0;
         cs <= '0; oe <= 1'b0; be <= '0; ta <= 1'b0; terr <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req) begin
               if (hit_any) begin
                  cs     <= NUM_BANKS'(1) << win_idx;
                  oe     <= !write;
                  be     <= win_lanes;
                  cnt_q  <= win_wait;
                  wait_q <= win_wait;
                  left_q <= beats_m1;
                  st_q   <= ST_ACC;
               end else begin
                  terr <= 1'b1;
                  st_q <= ST_ERR;
               end
            end
            ST_ACC: begin
               if (ta) begin
                  ta <= 1'b0;
                  if (left_q == '0) begin
                     cs <= '0; oe <= 1'b0; be <= '0;
                     st_q <= ST_IDLE;
                  end else begin
                     left_q <= left_q - 1'b1;
                     cnt_q  <= wait_q;
                  end
               end else if (cnt_q == '0) ta <= 1'b1;
               else cnt_q <= cnt_q - 1'b1;
            end
            ST_ERR: begin
               terr <= 1'b0;
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs));
   assert_ta_under_cs_R7: assert property (@(posedge clk) disable iff (!rst_n) ta |-> (cs != '0));
   assert_err_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      terr |-> (cs == '0 && !ta));
   assert_ta_no_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n) ta |=> !ta);
   assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cs != '0) && !ta) |=> $stable(cs));
   assert_oe_under_cs_R9: assert property (@(posedge clk) disable iff (!rst_n) oe |-> (cs != '0));
endmodule

// File: rtl/csel_wait_ctrl.sv
module csel_wait_ctrl
   import csel_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 32,
   parameter int MIN_LOG2  = 15,
   parameter int MAX_CODE  = 13,
   parameter int BEATS     = 4,
   parameter bit BURST_EN  = 1'b1,
   localparam int IDX_W    = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_bank,
   input  logic                 cfg_sel,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   input  logic                 acc_req,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic [AT_W-1:0]      acc_type,
   input  logic                 acc_write,
   input  logic [1:0]           acc_size,
   input  logic                 acc_burst,
   output logic [NUM_BANKS-1:0] cs,
   output logic                 oe,
   output logic [3:0]           be,
   output logic                 ta,
   output logic                 terr
);
   if (NUM_BANKS < 2 || NUM_BANKS > 16) begin : g_bad_banks
      $error("csel_wait_ctrl: NUM_BANKS out of range");
   end
   if (ADDR_W < CTL_W || MIN_LOG2 + MAX_CODE >= ADDR_W) begin : g_bad_addr
      $error("csel_wait_ctrl: ADDR_W too small for size codes");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("csel_wait_ctrl: BEATS must be at least 2");
   end

   logic [NUM_BANKS-1:0][ADDR_W-1:0] base;
   logic [NUM_BANKS-1:0][CTL_W-1:0]  ctl;
   logic                             hit_any;
   logic [IDX_W-1:0]                 win_idx;
   logic [CTL_W-1:0]                 win_ctl;
   logic [3:0]                       lanes;

   csel_bank_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .bank(cfg_bank), .sel(cfg_sel),
      .wdata(cfg_wdata), .base(base), .ctl(ctl));

   csel_bank_match #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2),
                     .MAX_CODE(MAX_CODE)) match_i (
      .base(base), .ctl(ctl), .addr(acc_addr), .atype(acc_type),
      .hit_any(hit_any), .win_idx(win_idx));

   assign win_ctl = ctl[win_idx];
   assign lanes   = lane_mask(win_ctl[F_PW_LO +: 2], acc_size, acc_addr[1:0]);

   csel_wait_seq #(.NUM_BANKS(NUM_BANKS), .BEATS(BEATS), .BURST_EN(BURST_EN)) seq_i (
      .clk(clk), .rst_n(rst_n), .req(acc_req), .hit_any(hit_any), .win_idx(win_idx),
      .win_wait(win_ctl[F_WAIT_LO +: WAIT_W]), .win_lanes(lanes), .write(acc_write),
      .burst(acc_burst), .cs(cs), .oe(oe), .be(be), .ta(ta), .terr(terr));
endmodule

// File: tb/csel_wait_ctrl_tb.sv
module csel_wait_ctrl_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [2:0] cfg_bank = '0;
   logic [31:0] cfg_wdata = '0, acc_addr = '0;
   logic acc_req = 1'b0, acc_write = 1'b0, acc_burst = 1'b0;
   logic [2:0] acc_type = '0;
   logic [1:0] acc_size = 2'd2;
   logic [7:0] cs;
   logic oe, ta, terr;
   logic [3:0] be;
   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   csel_wait_ctrl dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_addr(acc_addr),
      .acc_type(acc_type), .acc_write(acc_write), .acc_size(acc_size), .acc_burst(acc_burst),
      .cs(cs), .oe(oe), .be(be), .ta(ta), .terr(terr));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctlw(input bit v, input bit aten, input int at,
                                        input int pw, input int sz, input int w);
      return (32'(v) << 14) | (32'(aten) << 13) | (32'(at) << 10) | (32'(pw) << 8) |
             (32'(sz) << 4) | 32'(w);
   endfunction

   task automatic cfg_write(input int bank, input bit sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bank = 3'(bank); cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // exp_bank < 0 means no match expected
   task automatic run_access(input string tag, input logic [31:0] addr, input int at,
                             input bit wr, input int sz, input bit burst, input int exp_bank,
                             input int w, input logic [3:0] exp_be);
      int n;
      @(negedge clk);
      acc_req = 1'b1; acc_addr = addr; acc_type = 3'(at); acc_write = wr;
      acc_size = 2'(sz); acc_burst = burst;
      @(negedge clk);
      acc_req = 1'b0;
      if (exp_bank < 0) begin
         chk({tag, " terr strobe"}, {cs, 2'b0, terr, ta}, 32'h2);
         @(negedge clk);
         chk({tag, " terr one cycle"}, {cs, 2'b0, terr, ta}, 32'h0);
         return;
      end
      chk({tag, " cs"}, 32'(cs), 32'(8'(1) << exp_bank));
      chk({tag, " be/oe"}, {be, 3'b0, oe}, {exp_be, 3'b0, !wr});
      for (int b = 0; b < (burst ? 4 : 1); b++) begin
         n = 0;
         if (b > 0) begin @(negedge clk); n = 1; end
         while (!ta && n < 40) begin @(negedge clk); n++; end
         chk($sformatf("%s beat%0d ta delay", tag, b), 32'(n), 32'(b == 0 ? w + 1 : w + 2));
      end
      @(negedge clk);
      chk({tag, " release"}, {cs, 3'b0, ta}, 32'h0);
   endtask

   task automatic t_reset;
      chk("R1 reset outputs", {cs, be, 2'b0, oe, ta, terr}, 32'h0);
      run_access("R1 R7 boot bank", 32'h9000_0000, 0, 1'b0, 2, 1'b0, 0, 15, 4'hF);
   endtask

   task automatic t_setup_and_size;
      cfg_write(0, 1'b0, 32'hF000_0000);
      cfg_write(0, 1'b1, ctlw(1, 0, 0, 0, 0, 1));
      cfg_write(1, 1'b0, 32'h1000_0000);
      cfg_write(1, 1'b1, ctlw(1, 0, 0, 2, 0, 2));
      run_access("R2 R3 bank1 top of 32K", 32'h1000_7FFC, 0, 1'b0, 2, 1'b0, 1, 2, 4'hF);
      run_access("R3 R6 past 32K", 32'h1000_8000, 0, 1'b0, 2, 1'b0, -1, 0, 4'h0);
      run_access("R3 bank0 8-bit", 32'hF000_0003, 0, 1'b0, 0, 1'b0, 0, 1, 4'h1);
   endtask

   task automatic t_type_and_256m;
      cfg_write(2, 1'b0, 32'h2000_0000);
      cfg_write(2, 1'b1, ctlw(1, 1, 5, 1, 13, 0));
      run_access("R3 R4 256M type match", 32'h2FFF_FFF0, 5, 1'b0, 2, 1'b0, 2, 0, 4'h3);
      run_access("R4 type mismatch", 32'h2FFF_FFF0, 3, 1'b0, 2, 1'b0, -1, 0, 4'h0);
      run_access("R3 past 256M", 32'h3000_0000, 5, 1'b0, 2, 1'b0, -1, 0, 4'h0);
   endtask

   task automatic t_priority;
      cfg_write(3, 1'b0, 32'h1000_0000);
      cfg_write(3, 1'b1, ctlw(1, 0, 0, 2, 4, 7));
      run_access("R5 overlap lowest wins", 32'h1000_0100, 0, 1'b0, 2, 1'b0, 1, 2, 4'hF);
      run_access("R5 only bank3", 32'h1004_0000, 0, 1'b0, 2, 1'b0, 3, 7, 4'hF);
   endtask

   task automatic t_lanes;
      run_access("R9 32b byte off1", 32'h1000_0001, 0, 1'b0, 0, 1'b0, 1, 2, 4'h2);
      run_access("R9 32b half hi write", 32'h1000_0002, 0, 1'b1, 1, 1'b0, 1, 2, 4'hC);
      run_access("R9 16b byte odd", 32'h2000_0001, 5, 1'b0, 0, 1'b0, 2, 0, 4'h2);
   endtask

   task automatic t_burst;
      run_access("R8 burst w7", 32'h1004_0000, 0, 1'b0, 2, 1'b1, 3, 7, 4'hF);
      run_access("R8 burst w0", 32'h2000_0010, 5, 1'b1, 2, 1'b1, 2, 0, 4'h3);
   endtask

   task automatic t_busy;
      int bad = 0, n = 0;
      @(negedge clk);
      acc_req = 1'b1; acc_addr = 32'h1004_0000; acc_size = 2'd2; acc_burst = 1'b0;
      acc_write = 1'b0; acc_type = '0;
      @(negedge clk);
      acc_addr = 32'h1000_0000;        // request stays high, now aimed at bank1
      while (!ta && n < 40) begin
         if (cs !== 8'h08) bad++;
         @(negedge clk); n++;
      end
      chk("R10 cs held during busy request", 32'(bad), 32'h0);
      chk("R10 ta delay unchanged", 32'(n), 32'd8);
      acc_req = 1'b0;
      @(negedge clk);
      chk("R10 no second access", {cs, 3'b0, ta}, 32'h0);
      @(negedge clk);
      chk("R10 still idle", {cs, 3'b0, ta}, 32'h0);
   endtask

   task automatic t_disable;
      cfg_write(3, 1'b1, ctlw(0, 0, 0, 2, 4, 7));
      run_access("R2 disabled bank", 32'h1004_0000, 0, 1'b0, 2, 1'b0, -1, 0, 4'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setup_and_size();
      t_type_and_256m();
      t_priority();
      t_lanes();
      t_burst();
      t_busy();
      t_disable();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule